// File: doc/BRIEF.md
# TDM Per-Channel Bypass Output Selector

This block decides, slot by slot, which byte leaves on a parallel TDM output stream. The stream carries one channel per clock cycle. A frame pulse marks channel 0, and a free-running counter numbers the channels in between. A control memory holds one word per output channel, written by the CPU. Each word has an enable flag, a message flag, a bypass flag and a byte. The byte is sent as a fixed message when the message flag is set.

For each slot the block sends one of four things:
- nothing, with the enable line low;
- the stored message byte;
- the byte that arrived on the same-numbered input channel one frame earlier (bypass);
- a switched byte that the serial side presents for that slot.

Enable and message take priority over bypass. Bypass is honoured only in the first two timing modes.

Every input byte is written into a receive memory with two banks that swap at each frame start. The CPU reads from the bank that holds the last complete frame. The bypass path draws its one-frame-old byte from that same bank, so a bypassed channel is still captured and stays readable.

Top module: `tdm_bypass_sel`

## Requirements
- R1: The channel number is 0 in a cycle where `frame_i` is high. Otherwise it advances by one, wrapping from NCH-1 to 0. `tx_slot_o` shows the channel number of the cycle before.
- R2: A control word's enable bit is bit DW+2 of `cm_wdata_i`. When that bit is clear, the slot's `tx_oe_o` is 0 and `tx_byte_o` is 0, whatever the other bits hold.
- R3: The message bit is bit DW+1 and the message byte is bits DW-1:0. With enable and message set, the slot sends the message byte, whatever the bypass bit and mode are.
- R4: The bypass bit is bit DW. With enable and bypass set, message clear, and `tmode_i` equal to 0 or 1 (timing modes 1 and 2), output slot N sends the byte received on input slot N one frame earlier.
- R5: With `tmode_i` equal to 2 or 3, the bypass bit is ignored. An enabled non-message slot sends `sw_byte_i`.
- R6: With enable set and message and bypass clear, the slot sends the `sw_byte_i` value present in that slot's cycle.
- R7: A control write takes effect from the slot after the write cycle. A write to the entry of the current slot does not change that slot's output.
- R8: Every input byte is stored, bypassed or not. `rd_data_o` returns, one cycle after `rd_addr_i` is presented, the byte received at that channel in the last complete frame.
- R9: Reset clears the outputs and every control word, so all slots stay disabled until written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one channel per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | High in the cycle of channel 0 |
| tmode_i | input | 2 | Timing mode code 0..3 for modes 1..4 |
| rx_byte_i | input | DW | Parallel input byte of the current channel |
| sw_byte_i | input | DW | Switched byte offered for the current output channel |
| cm_we_i | input | 1 | Control memory write strobe |
| cm_addr_i | input | CW | Control memory channel address |
| cm_wdata_i | input | DW+3 | {enable, message, bypass, byte} |
| rd_addr_i | input | CW | CPU receive-memory read address |
| rd_data_o | output | DW | CPU read data, last complete frame |
| tx_byte_o | output | DW | Output byte |
| tx_oe_o | output | 1 | Output enable of the slot shown |
| tx_slot_o | output | CW | Channel number of the slot shown |

## Verification
Two situations are hard to reach from the ports.

The first is a bypassed byte, which only shows up a full frame after it entered. The stimulus therefore runs every table row as two frames. The first frame programs all control words while feeding a known input pattern. The second frame checks each output slot against the previous frame's input, and reads the receive memory at the same time.

The second is the write-versus-slot race of R7. A directed frame rewrites the entry of the slot being sent and, separately, the entry of the next slot, then checks both slots and the following frame.

// File: rtl/tdm_sel_pkg.sv
package tdm_sel_pkg;

  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_MSG = 2'd1,
    SRC_BYP = 2'd2,
    SRC_SW  = 2'd3
  } src_e;

  // Bypass is honoured only for mode codes 0 and 1.
  function automatic logic mode_allows_bypass(input logic [1:0] mode);
    return (mode == 2'd0) || (mode == 2'd1);
  endfunction

  // Priority: enable, then message, then bypass (mode gated), then switched.
  function automatic src_e pick_source(input logic oe, input logic msg,
                                       input logic byp, input logic [1:0] mode);
    if (!oe)                               return SRC_OFF;
    if (msg)                               return SRC_MSG;
    if (byp && mode_allows_bypass(mode))   return SRC_BYP;
    return SRC_SW;
  endfunction

  // Channel stepping: frame pulse restarts, otherwise wrap at nch.
  function automatic int unsigned step_slot(input int unsigned prev,
                                            input logic frame,
                                            input int unsigned nch);
    if (frame)             return 0;
    if (prev >= nch - 1)   return 0;
    return prev + 1;
  endfunction

endpackage

// File: rtl/tsel_slot_counter.sv
module tsel_slot_counter
  import tdm_sel_pkg::*;
#(
  parameter int NCH = 32,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_i,
  output logic [CW-1:0] slot_now,
  output logic          frame_start
);

  logic [CW-1:0] prev_q;

  always_comb begin
    slot_now    = CW'(step_slot(int'(prev_q), frame_i, NCH));
    frame_start = (slot_now == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= CW'(NCH - 1);
    else        prev_q <= slot_now;
  end

endmodule

// File: rtl/tsel_ctrl_mem.sv
module tsel_ctrl_mem #(
  parameter int NCH = 32,
  parameter int DW  = 8,
  localparam int CW  = $clog2(NCH),
  localparam int CTW = DW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we_i,
  input  logic [CW-1:0]  waddr_i,
  input  logic [CTW-1:0] wdata_i,
  input  logic [CW-1:0]  raddr_i,
  output logic [CTW-1:0] rdata_o
);

  logic [CTW-1:0] words [NCH];

  // Read of the registered array: a write lands at the edge, so the
  // slot in progress still sees the old word.
  assign rdata_o = words[raddr_i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) words[i] <= '0;
    end else if (we_i) begin
      words[waddr_i] <= wdata_i;
    end
  end

endmodule

// File: rtl/tsel_rx_mem.sv
module tsel_rx_mem #(
  parameter int NCH = 32,
  parameter int DW  = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] slot_now,
  input  logic          frame_start,
  input  logic [DW-1:0] rx_byte_i,
  input  logic [CW-1:0] rd_addr_i,
  output logic [DW-1:0] byp_byte_o,
  output logic [DW-1:0] rd_data_o
);

  logic [DW-1:0] mem [2][NCH];
  logic          bank_q;
  logic          wbank_now;
  logic          done_bank;

  always_comb begin
    wbank_now  = frame_start ? ~bank_q : bank_q;
    done_bank  = ~wbank_now;
    byp_byte_o = mem[done_bank][slot_now];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q    <= 1'b0;
      rd_data_o <= '0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NCH; i++) mem[b][i] <= '0;
    end else begin
      bank_q                   <= wbank_now;
      mem[wbank_now][slot_now] <= rx_byte_i;
      rd_data_o                <= mem[done_bank][rd_addr_i];
    end
  end

  // R8: the bank being written is never the bank being read.
  assert_bank_split_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> bank_q != $past(bank_q));

endmodule

// File: rtl/tdm_bypass_sel.sv
module tdm_bypass_sel
  import tdm_sel_pkg::*;
#(
  parameter int NCH = 32,
  parameter int DW  = 8,
  localparam int CW  = $clog2(NCH),
  localparam int CTW = DW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_i,
  input  logic [1:0]     tmode_i,
  input  logic [DW-1:0]  rx_byte_i,
  input  logic [DW-1:0]  sw_byte_i,
  input  logic           cm_we_i,
  input  logic [CW-1:0]  cm_addr_i,
  input  logic [CTW-1:0] cm_wdata_i,
  input  logic [CW-1:0]  rd_addr_i,
  output logic [DW-1:0]  rd_data_o,
  output logic [DW-1:0]  tx_byte_o,
  output logic           tx_oe_o,
  output logic [CW-1:0]  tx_slot_o
);

  logic [CW-1:0]  slot_now;
  logic           frame_start;
  logic [CTW-1:0] cur_word;
  logic [DW-1:0]  byp_byte;

  tsel_slot_counter #(.NCH(NCH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i),
    .slot_now(slot_now), .frame_start(frame_start)
  );

  tsel_ctrl_mem #(.NCH(NCH), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we_i(cm_we_i), .waddr_i(cm_addr_i),
    .wdata_i(cm_wdata_i), .raddr_i(slot_now), .rdata_o(cur_word)
  );

  tsel_rx_mem #(.NCH(NCH), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .slot_now(slot_now), .frame_start(frame_start),
    .rx_byte_i(rx_byte_i), .rd_addr_i(rd_addr_i),
    .byp_byte_o(byp_byte), .rd_data_o(rd_data_o)
  );

  // Named events for the checks.
  logic          cur_oe, cur_msg, cur_byp, mode_ok;
  logic [DW-1:0] cur_msg_byte;
  src_e          src;
  logic [DW-1:0] sel_byte;

  always_comb begin
    cur_oe       = cur_word[DW+2];
    cur_msg      = cur_word[DW+1];
    cur_byp      = cur_word[DW];
    cur_msg_byte = cur_word[DW-1:0];
    mode_ok      = mode_allows_bypass(tmode_i);
    src          = pick_source(cur_oe, cur_msg, cur_byp, tmode_i);
    case (src)
      SRC_MSG: sel_byte = cur_msg_byte;
      SRC_BYP: sel_byte = byp_byte;
      SRC_SW:  sel_byte = sw_byte_i;
      default: sel_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_byte_o <= '0;
      tx_oe_o   <= 1'b0;
      tx_slot_o <= '0;
    end else begin
      tx_byte_o <= sel_byte;
      tx_oe_o   <= (src != SRC_OFF);
      tx_slot_o <= slot_now;
    end
  end

  assert_slot_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i |=> tx_slot_o == '0);

  assert_oe_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_oe |=> (!tx_oe_o && tx_byte_o == '0));

  assert_msg_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_oe && cur_msg) |=> (tx_oe_o && tx_byte_o == $past(cur_msg_byte)));

  assert_bypass_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_oe && !cur_msg && cur_byp && mode_ok) |=> tx_byte_o == $past(byp_byte));

  assert_mode_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_oe && !cur_msg && !mode_ok) |=> tx_byte_o == $past(sw_byte_i));

  assert_switched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_oe && !cur_msg && !cur_byp) |=> tx_byte_o == $past(sw_byte_i));

endmodule

// File: tb/test_tdm_bypass_sel.sv
module test_tdm_bypass_sel;

  localparam int NCH = 32;
  localparam int DW  = 8;
  localparam int CW  = $clog2(NCH);
  localparam int CTW = DW + 3;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           frame_i;
  logic [1:0]     tmode_i;
  logic [DW-1:0]  rx_byte_i, sw_byte_i;
  logic           cm_we_i;
  logic [CW-1:0]  cm_addr_i;
  logic [CTW-1:0] cm_wdata_i;
  logic [CW-1:0]  rd_addr_i;
  logic [DW-1:0]  rd_data_o, tx_byte_o;
  logic           tx_oe_o;
  logic [CW-1:0]  tx_slot_o;

  tdm_bypass_sel #(.NCH(NCH), .DW(DW)) i_tdm_bypass_sel (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .tmode_i(tmode_i),
    .rx_byte_i(rx_byte_i), .sw_byte_i(sw_byte_i), .cm_we_i(cm_we_i),
    .cm_addr_i(cm_addr_i), .cm_wdata_i(cm_wdata_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .tx_byte_o(tx_byte_o), .tx_oe_o(tx_oe_o),
    .tx_slot_o(tx_slot_o)
  );

  always #4 clk = ~clk;  // 125 MHz

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  int fr = 0;

  // Row: [6:5] mode code, [4] enable, [3] message, [2] bypass,
  //      [1:0] expected source 0 off, 1 message, 2 bypass, 3 switched
  localparam logic [6:0] VEC [8] = '{
    {2'd0, 1'b1, 1'b0, 1'b1, 2'd2},
    {2'd1, 1'b1, 1'b0, 1'b1, 2'd2},
    {2'd2, 1'b1, 1'b0, 1'b1, 2'd3},
    {2'd3, 1'b1, 1'b0, 1'b1, 2'd3},
    {2'd0, 1'b1, 1'b0, 1'b0, 2'd3},
    {2'd0, 1'b0, 1'b1, 1'b1, 2'd0},
    {2'd1, 1'b0, 1'b0, 1'b0, 2'd0},
    {2'd1, 1'b1, 1'b1, 1'b1, 2'd1}
  };

  function automatic logic [7:0] rx_pat(input int f, input int s);
    return 8'((f * 37 + s * 5 + 1) & 255);
  endfunction

  function automatic logic [7:0] sw_pat(input int f, input int s);
    return 8'(((f * 13) ^ (s * 3)) & 255) ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h (frame %0d)", req, act, exp, fr);
    end
  endtask

  // Called at a negedge; drives one slot and returns at the next negedge,
  // where the outputs of that slot are visible.
  task automatic one_slot(input logic f_p, input logic [7:0] rx, input logic [7:0] sw,
                          input logic we, input logic [CW-1:0] a,
                          input logic [CTW-1:0] wd, input logic [CW-1:0] ra);
    frame_i = f_p; rx_byte_i = rx; sw_byte_i = sw;
    cm_we_i = we; cm_addr_i = a; cm_wdata_i = wd; rd_addr_i = ra;
    @(negedge clk);
    cm_we_i = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frame_i = 1'b0; tmode_i = 2'd0; rx_byte_i = '0; sw_byte_i = '0;
    cm_we_i = 1'b0; cm_addr_i = '0; cm_wdata_i = '0; rd_addr_i = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset oe", int'(tx_oe_o), 0);
    chk("R9 reset byte", int'(tx_byte_o), 0);
    rst_n = 1'b1;

    // R9: no writes yet, every slot disabled.
    for (int s = 0; s < NCH; s++) begin
      one_slot(s == 0, rx_pat(fr, s), sw_pat(fr, s), 1'b0, '0, '0, '0);
      chk("R9 disabled after reset", int'(tx_oe_o), 0);
    end
    fr++;

    // R1: early frame pulse, then free wrap.
    for (int s = 0; s < 10; s++) begin
      one_slot(s == 0, 8'h00, 8'h00, 1'b0, '0, '0, '0);
      chk("R1 count", int'(tx_slot_o), s);
    end
    one_slot(1'b1, 8'h00, 8'h00, 1'b0, '0, '0, '0);
    chk("R1 early frame restart", int'(tx_slot_o), 0);
    for (int s = 1; s < NCH + 3; s++) begin
      one_slot(1'b0, 8'h00, 8'h00, 1'b0, '0, '0, '0);
      chk("R1 wrap", int'(tx_slot_o), s % NCH);
    end
    // finish the pending frame so the next starts cleanly
    for (int s = 3; s < NCH; s++) one_slot(1'b0, 8'h00, 8'h00, 1'b0, '0, '0, '0);
    fr++;

    // Table walk: program frame, then check frame.
    for (int r = 0; r < 8; r++) begin
      logic [6:0] v;
      v = VEC[r];
      tmode_i = v[6:5];
      for (int s = 0; s < NCH; s++)
        one_slot(s == 0, rx_pat(fr, s), sw_pat(fr, s), 1'b1, CW'(s),
                 {v[4], v[3], v[2], 8'hA0 ^ 8'(s)}, '0);
      fr++;
      for (int s = 0; s < NCH; s++) begin
        one_slot(s == 0, rx_pat(fr, s), sw_pat(fr, s), 1'b0, '0, '0, CW'(s));
        chk("R1 slot", int'(tx_slot_o), s);
        chk("R8 receive read", int'(rd_data_o), int'(rx_pat(fr - 1, s)));
        case (v[1:0])
          2'd0: begin
            chk("R2 oe low", int'(tx_oe_o), 0);
            chk("R2 byte zero", int'(tx_byte_o), 0);
          end
          2'd1: begin
            chk("R3 oe", int'(tx_oe_o), 1);
            chk("R3 message", int'(tx_byte_o), int'(8'hA0 ^ 8'(s)));
          end
          2'd2: begin
            chk("R4 oe", int'(tx_oe_o), 1);
            chk("R4 bypass", int'(tx_byte_o), int'(rx_pat(fr - 1, s)));
          end
          default: begin
            chk(v[2] ? "R5 bypass ignored" : "R6 switched", int'(tx_byte_o),
                int'(sw_pat(fr, s)));
          end
        endcase
      end
      fr++;
    end

    // R7: message on all slots (left by the last row); rewrite mid frame.
    for (int s = 0; s < NCH; s++) begin
      logic we_l;
      logic [CW-1:0] a_l;
      logic [CTW-1:0] d_l;
      we_l = 1'b0; a_l = '0; d_l = '0;
      if (s == 5) begin we_l = 1'b1; a_l = CW'(5); d_l = '0; end
      if (s == 6) begin we_l = 1'b1; a_l = CW'(7); d_l = {3'b110, 8'h3C}; end
      one_slot(s == 0, rx_pat(fr, s), sw_pat(fr, s), we_l, a_l, d_l, '0);
      if (s == 5) chk("R7 same-slot write keeps old", int'(tx_byte_o), int'(8'hA5));
      if (s == 6) chk("R7 untouched slot", int'(tx_byte_o), int'(8'hA6));
      if (s == 7) chk("R7 next-slot write applies", int'(tx_byte_o), 8'h3C);
    end
    fr++;
    for (int s = 0; s < NCH; s++) begin
      one_slot(s == 0, rx_pat(fr, s), sw_pat(fr, s), 1'b0, '0, '0, '0);
      if (s == 5) chk("R7 write seen next frame", int'(tx_oe_o), 0);
    end
    fr++;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule